// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two byte-wide buses, called A and B, and moves data between them in either direction or both at once. Each direction owns a capture register with its own clock: the A-to-B register samples the A bus and the B-to-A register samples the B bus. A per-direction source select picks what each side presents. It is either the live value arriving from the opposite bus or the contents of that direction's register. The outputs are never inverted.

Two enables set which sides drive. `dir_b` (active high) turns on the B-side drivers and `a_oe_n` (active low) turns on the A-side drivers. Together they decode to four named modes: MODE_ISOLATE (neither side driven), MODE_A_DRIVE (A side only), MODE_B_DRIVE (B side only) and MODE_BOTH (both sides). The mode is a pure decode of the two pins, with no transitions of its own. It moves from one mode to any other as soon as a pin changes.

The only state is held in the two capture registers. Each register has two states: cleared by the asynchronous reset, or loaded by a rising edge of its own clock. The buses appear as separate input, output and output-enable signals. In MODE_BOTH with both selects on live data, each output feeds the other bus's input. A bus that nothing else drives therefore keeps its last value.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A rising edge of `a2b_clk` loads `a_in` into the A-to-B register.
- R2: A rising edge of `b2a_clk` loads `b_in` into the B-to-A register.
- R3: Register loading happens whatever the values of `a2b_sel`, `b2a_sel`, `dir_b` and `a_oe_n`, including in MODE_ISOLATE.
- R4: `b_out` equals `a_in` when `a2b_sel` is 0 and equals the A-to-B register when `a2b_sel` is 1, without inversion, whether or not the B side is enabled.
- R5: `a_out` equals `b_in` when `b2a_sel` is 0 and equals the B-to-A register when `b2a_sel` is 1, without inversion, whether or not the A side is enabled.
- R6: `b_oe` is 1 exactly when `dir_b` is 1, and `a_oe` is 1 exactly when `a_oe_n` is 0. The mode is ISOLATE for (dir_b=0, a_oe_n=1), A_DRIVE for (0,0), B_DRIVE for (1,1) and BOTH for (1,0).
- R7: In MODE_BOTH with both selects at 0, a value placed on one bus appears on the other bus. When the external driver is released, both buses keep that value.
- R8: A load into one direction's register never changes the other direction's register.
- R9: `rst_n` low clears both registers to 0 at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| a2b_clk | input | 1 | Load clock of the A-to-B register |
| b2a_clk | input | 1 | Load clock of the B-to-A register |
| a2b_sel | input | 1 | B-side source: 0 live A bus, 1 stored A-to-B value |
| b2a_sel | input | 1 | A-side source: 0 live B bus, 1 stored B-to-A value |
| dir_b | input | 1 | Active-high enable of the B-side drivers |
| a_oe_n | input | 1 | Active-low enable of the A-side drivers |
| a_in | input | WIDTH | Value present on the A bus |
| a_out | output | WIDTH | Value the block offers to the A bus |
| a_oe | output | 1 | A-side driver enable |
| b_in | input | WIDTH | Value present on the B bus |
| b_out | output | WIDTH | Value the block offers to the B bus |
| b_oe | output | 1 | B-side driver enable |

## Verification
The bench builds the block with its default WIDTH of 8. That is wide enough for patterns such as 0x5A and 0xC3, which give each bit its own value in both directions, so a swapped, dropped or inverted bit shows at the outputs. At this width, all sixteen combinations of the two enables and two selects are walked against known stored values. Bus values are resolved in the bench, and this makes the loop-back hold case observable in MODE_BOTH.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Encoding is {B side driven, A side driven}.
    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'b00,
        MODE_A_DRIVE = 2'b01,
        MODE_B_DRIVE = 2'b10,
        MODE_BOTH    = 2'b11
    } xcvr_mode_e;

    function automatic xcvr_mode_e decode_mode(input logic dir_b, input logic a_oe_n);
        return xcvr_mode_e'({dir_b, ~a_oe_n});
    endfunction

endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/route_mux.sv
module route_mux #(
    parameter int WIDTH = 8
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        y = use_stored ? stored : live;
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             a2b_clk,
    input  logic             b2a_clk,
    input  logic             a2b_sel,
    input  logic             b2a_sel,
    input  logic             dir_b,
    input  logic             a_oe_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    localparam int NUM_PATH = 2;
    localparam int PATH_AB  = 0;
    localparam int PATH_BA  = 1;

    logic [NUM_PATH-1:0] path_clk;
    logic [NUM_PATH-1:0] path_sel;
    logic [WIDTH-1:0]    path_d [NUM_PATH];
    logic [WIDTH-1:0]    path_q [NUM_PATH];
    logic [WIDTH-1:0]    path_y [NUM_PATH];
    logic [WIDTH-1:0]    q_ab;
    logic [WIDTH-1:0]    q_ba;
    xcvr_mode_e          mode;

    assign path_clk[PATH_AB] = a2b_clk;
    assign path_clk[PATH_BA] = b2a_clk;
    assign path_sel[PATH_AB] = a2b_sel;
    assign path_sel[PATH_BA] = b2a_sel;
    assign path_d[PATH_AB]   = a_in;
    assign path_d[PATH_BA]   = b_in;

    // One register and one source mux per direction; each register
    // lives in its own clock domain.
    for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
        capture_reg #(.WIDTH(WIDTH)) u_cap (
            .clk   (path_clk[p]),
            .rst_n (rst_n),
            .d     (path_d[p]),
            .q     (path_q[p])
        );
        route_mux #(.WIDTH(WIDTH)) u_mux (
            .use_stored (path_sel[p]),
            .live       (path_d[p]),
            .stored     (path_q[p]),
            .y          (path_y[p])
        );
    end

    assign q_ab  = path_q[PATH_AB];
    assign q_ba  = path_q[PATH_BA];
    assign b_out = path_y[PATH_AB];
    assign a_out = path_y[PATH_BA];

    assign mode = decode_mode(dir_b, a_oe_n);

    always_comb begin
        unique case (mode)
            MODE_ISOLATE: begin a_oe = 1'b0; b_oe = 1'b0; end
            MODE_A_DRIVE: begin a_oe = 1'b1; b_oe = 1'b0; end
            MODE_B_DRIVE: begin a_oe = 1'b0; b_oe = 1'b1; end
            MODE_BOTH:    begin a_oe = 1'b1; b_oe = 1'b1; end
            default:      begin a_oe = 1'b0; b_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             rst_n,
    input logic             a2b_clk,
    input logic             b2a_clk,
    input logic             a2b_sel,
    input logic             b2a_sel,
    input logic             dir_b,
    input logic             a_oe_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             a_oe,
    input logic             b_oe,
    input logic [WIDTH-1:0] q_ab,
    input logic [WIDTH-1:0] q_ba
);
    logic armed_ab, armed_ba;

    always_ff @(posedge a2b_clk or negedge rst_n) begin
        if (!rst_n) armed_ab <= 1'b0;
        else        armed_ab <= 1'b1;
    end

    always_ff @(posedge b2a_clk or negedge rst_n) begin
        if (!rst_n) armed_ba <= 1'b0;
        else        armed_ba <= 1'b1;
    end

    p_load_ab_r1: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        armed_ab |-> (q_ab == $past(a_in)));

    p_load_ba_r2: assert property (@(posedge b2a_clk) disable iff (!rst_n)
        armed_ba |-> (q_ba == $past(b_in)));

    p_b_live_r4: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        !a2b_sel |-> (b_out == a_in));

    p_b_stored_r4: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        a2b_sel |-> (b_out == q_ab));

    p_a_live_r5: assert property (@(posedge b2a_clk) disable iff (!rst_n)
        !b2a_sel |-> (a_out == b_in));

    p_a_stored_r5: assert property (@(posedge b2a_clk) disable iff (!rst_n)
        b2a_sel |-> (a_out == q_ba));

    p_enables_r6: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        (b_oe == dir_b) && (a_oe == !a_oe_n));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .rst_n   (rst_n),
    .a2b_clk (a2b_clk),
    .b2a_clk (b2a_clk),
    .a2b_sel (a2b_sel),
    .b2a_sel (b2a_sel),
    .dir_b   (dir_b),
    .a_oe_n  (a_oe_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .b_out   (b_out),
    .a_oe    (a_oe),
    .b_oe    (b_oe),
    .q_ab    (q_ab),
    .q_ba    (q_ba)
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
    localparam int W = 8;

    typedef struct packed {
        logic       dir;
        logic       oe_n;
        logic       sab;
        logic       sba;
        logic       eoa;
        logic       eob;
        logic [7:0] ea;
        logic [7:0] eb;
    } vec_t;

    // Stored values: A-to-B = 0x3C, B-to-A = 0xA5; live a=0x5A, b=0xC3.
    localparam vec_t VECS [16] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'hC3,8'h5A},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'hA5,8'h5A},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'hC3,8'h3C},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'hA5,8'h3C},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hC3,8'h5A},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'hA5,8'h5A},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'hC3,8'h3C},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'hA5,8'h3C},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'hC3,8'h5A},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'hA5,8'h5A},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,8'hC3,8'h3C},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,8'hA5,8'h3C},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,8'hC3,8'h5A},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,8'hA5,8'h5A},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,8'hC3,8'h3C},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,8'hA5,8'h3C}
    };

    logic         clk = 1'b0;
    logic         rst_n, a2b_clk, b2a_clk, a2b_sel, b2a_sel, dir_b, a_oe_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    int           n_run = 0;
    int           n_fail = 0;
    int           wd = 0;

    always #2 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W)) u0 (
        .rst_n(rst_n), .a2b_clk(a2b_clk), .b2a_clk(b2a_clk),
        .a2b_sel(a2b_sel), .b2a_sel(b2a_sel), .dir_b(dir_b), .a_oe_n(a_oe_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic pulse_ab();
        #1 a2b_clk = 1'b1;
        #2 a2b_clk = 1'b0;
        #1;
    endtask

    task automatic pulse_ba();
        #1 b2a_clk = 1'b1;
        #2 b2a_clk = 1'b0;
        #1;
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; a2b_clk = 1'b0; b2a_clk = 1'b0;
        a2b_sel = 1'b1; b2a_sel = 1'b1; dir_b = 1'b0; a_oe_n = 1'b1;
        a_in = '0; b_in = '0;
        #10;
        chk("R9 reset b_out", b_out, 8'h00);
        chk("R9 reset a_out", a_out, 8'h00);
        rst_n = 1'b1;
        #5;

        // R1 / R8: load A-to-B only.
        a_in = 8'h3C; pulse_ab();
        chk("R1 load ab", b_out, 8'h3C);
        chk("R8 ba untouched", a_out, 8'h00);
        // R2 / R8: load B-to-A only.
        b_in = 8'hA5; pulse_ba();
        chk("R2 load ba", a_out, 8'hA5);
        chk("R8 ab untouched", b_out, 8'h3C);

        // Walk every enable/select combination (R4, R5, R6).
        a_in = 8'h5A; b_in = 8'hC3;
        for (int i = 0; i < 16; i++) begin
            dir_b = VECS[i].dir; a_oe_n = VECS[i].oe_n;
            a2b_sel = VECS[i].sab; b2a_sel = VECS[i].sba;
            #2;
            chk("R5 a_out", a_out, VECS[i].ea);
            chk("R4 b_out", b_out, VECS[i].eb);
            chk("R6 a_oe", {7'd0, a_oe}, {7'd0, VECS[i].eoa});
            chk("R6 b_oe", {7'd0, b_oe}, {7'd0, VECS[i].eob});
        end

        // R3: loads in MODE_ISOLATE with live selects.
        dir_b = 1'b0; a_oe_n = 1'b1; a2b_sel = 1'b0; b2a_sel = 1'b0;
        a_in = 8'h71; b_in = 8'h1E;
        pulse_ab(); pulse_ba();
        a2b_sel = 1'b1; b2a_sel = 1'b1; #2;
        chk("R3 isolate ab", b_out, 8'h71);
        chk("R3 isolate ba", a_out, 8'h1E);
        // R3: loads in MODE_BOTH with stored selects.
        dir_b = 1'b1; a_oe_n = 1'b0; a_in = 8'h22; pulse_ab();
        chk("R3 both ab", b_out, 8'h22);
        chk("R8 ba kept", a_out, 8'h1E);

        // R9: reset clears both registers without a clock edge.
        rst_n = 1'b0; #1;
        chk("R9 async ab", b_out, 8'h00);
        chk("R9 async ba", a_out, 8'h00);
        rst_n = 1'b1; #2;

        // R7: loop-back hold in MODE_BOTH with live selects.
        a2b_sel = 1'b0; b2a_sel = 1'b0;
        a_in = 8'h96; #1;
        b_in = b_out; #1;               // B bus driven only by the block
        chk("R7 a to b", b_out, 8'h96);
        a_in = a_out; #1;               // external A driver released
        b_in = b_out; #1;
        chk("R7 hold a", a_out, 8'h96);
        chk("R7 hold b", b_out, 8'h96);
        b_in = 8'h69; #1;               // external B driver takes over
        a_in = a_out; #1;
        chk("R7 b to a", a_out, 8'h69);
        b_in = b_out; #1;               // B driver released
        a_in = a_out; #1;
        chk("R7 hold b2", b_out, 8'h69);

        // R8: B-to-A load leaves A-to-B register at its reset value.
        a2b_sel = 1'b1; b2a_sel = 1'b1;
        b_in = 8'hEE; pulse_ba();
        chk("R8 ab after ba load", b_out, 8'h00);
        chk("R2 ba value", a_out, 8'hEE);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule